// File: doc/BRIEF.md
# Console Keyboard and Display Register Interface

This block is a bus slave that lets a processor reach a byte-wide keyboard receiver and a byte-wide console transmitter through four 32-bit registers. The registers are word-aligned and sit in a 16-byte window at the top of the address space. Software can poll a ready flag in each direction. It can also set a per-direction enable so that the block raises an interrupt request line whenever that direction is ready.

On the device side, a one-cycle `kb_valid` strobe hands a received byte to the block. The block latches the byte and marks it as waiting until software reads the receive data register. For output, an accepted write to the transmit data register emits a one-cycle `tx_valid` strobe carrying the byte. The transmitter stays busy until the device answers with a `tx_done` pulse.

Bus reads are combinational: `bus_rdata` reflects the addressed register in the same cycle as `bus_rd`, and any side effect of the read takes hold at the next clock edge.

Top module: `cio_console_ctrl`

## Requirements
- R1: After reset the receive control register (offset 0x0) reads 0, the transmit control register (offset 0x8) reads 1, both interrupt request lines are 0 and `tx_valid` is 0.
- R2: A `kb_valid` pulse latches `kb_byte` and sets bit 0 (ready) of the receive control register from the next cycle. The byte then reads back in bits 7:0 of the receive data register (offset 0x4).
- R3: A read of the receive data register clears receive ready at the next edge. If `kb_valid` arrives in that same cycle, the new byte is stored and ready stays 1.
- R4: A second `kb_valid` before the data is read replaces the stored byte, and ready stays 1.
- R5: Bit 1 of the receive control register is a software-written interrupt enable that reads back. `irq_rx` is 1 exactly while receive ready and that enable are both 1.
- R6: A write to the transmit data register (offset 0xC) while transmit ready is 1 produces a `tx_valid` pulse one cycle long in the next cycle, with `tx_byte` equal to write data bits 7:0. Transmit ready drops to 0 at the same edge.
- R7: A `tx_done` pulse while transmit ready is 0 sets transmit ready to 1 from the next cycle.
- R8: A write to the transmit data register while transmit ready is 0 is ignored: there is no `tx_valid` pulse and ready stays 0.
- R9: Software writes never change either ready bit (bit 0 of offsets 0x0 and 0x8).
- R10: Bit 1 of the transmit control register is an interrupt enable. `irq_tx` is 1 exactly while transmit ready and that enable are both 1.
- R11: Unused register bits read as 0, and the transmit data register reads as 0. Accesses outside the window or to an address that is not word-aligned have no effect and read 0.
- R12: `bus_rdata` is 0 in any cycle without `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| kb_valid | input | 1 | Received byte is present this cycle |
| kb_byte | input | 8 | Received byte |
| tx_done | input | 1 | Device has finished sending the last byte |
| tx_valid | output | 1 | One-cycle strobe of a byte to send |
| tx_byte | output | 8 | Byte to send |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The bench builds the block with its defaults: 32-bit address and data, 8-bit bytes, and the window based at 0xFFFF0000. With these values, the full-width address compare can be exercised by addresses that differ from the window only in high bits, and misaligned offsets can be tried inside the window. Writing data with every upper bit set shows that none of those bits leak into the byte path or into read-back. The reference model runs a directed sequence covering each collision case: read with arrival, done with write, and write while busy. It then runs a stretch of random bus and device traffic, and all outputs are compared on every clock.

// File: rtl/cio_pkg.sv
`timescale 1ns/1ps
package cio_pkg;

    // Register slot selected by address bits 3:2 inside the window.
    typedef enum logic [1:0] {
        SLOT_RX_CTRL = 2'd0,
        SLOT_RX_DATA = 2'd1,
        SLOT_TX_CTRL = 2'd2,
        SLOT_TX_DATA = 2'd3
    } cio_slot_e;

    // Bit positions inside both control registers.
    localparam int unsigned CTRL_RDY_BIT = 0;
    localparam int unsigned CTRL_IE_BIT  = 1;

    // Decoded access for one bus cycle.
    typedef struct packed {
        logic      hit;
        logic      rd;
        logic      wr;
        cio_slot_e slot;
    } cio_access_t;

endpackage

// File: rtl/cio_decode.sv
`timescale 1ns/1ps
module cio_decode
    import cio_pkg::*;
#(
    parameter int unsigned             ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]       BASE_ADDR = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output cio_access_t       acc_o
);

    localparam int unsigned WIN_LSB = 4;

    logic in_window;
    logic aligned;

    always_comb begin
        in_window  = (addr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
        aligned    = (addr_i[1:0] == 2'b00);
        acc_o.hit  = in_window && aligned;
        acc_o.rd   = rd_i && in_window && aligned;
        acc_o.wr   = wr_i && in_window && aligned;
        acc_o.slot = cio_slot_e'(addr_i[3:2]);
    end

endmodule

// File: rtl/cio_rx_port.sv
`timescale 1ns/1ps
module cio_rx_port #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid_i,
    input  logic [BYTE_W-1:0] kb_byte_i,
    input  logic              ie_wr_i,
    input  logic              ie_val_i,
    input  logic              data_rd_i,
    output logic              rdy_o,
    output logic              ie_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              irq_o
);

    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [BYTE_W-1:0] data;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Arrival outranks the read-side clear so no byte is lost.
        if (kb_valid_i) begin
            st_d.rdy  = 1'b1;
            st_d.data = kb_byte_i;
        end else if (data_rd_i) begin
            st_d.rdy  = 1'b0;
        end
        if (ie_wr_i) begin
            st_d.ie = ie_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_o  = st_q.rdy;
    assign ie_o   = st_q.ie;
    assign data_o = st_q.data;
    assign irq_o  = st_q.rdy & st_q.ie;

    // R2
    rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kb_valid_i |=> (rdy_o && data_o == $past(kb_byte_i)));

    // R3
    rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && !kb_valid_i) |=> !rdy_o);

    // R5
    rx_ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_wr_i |=> $stable(ie_o));

endmodule

// File: rtl/cio_tx_port.sv
`timescale 1ns/1ps
module cio_tx_port #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie_wr_i,
    input  logic              ie_val_i,
    input  logic              data_wr_i,
    input  logic [BYTE_W-1:0] wbyte_i,
    input  logic              done_i,
    output logic              rdy_o,
    output logic              ie_o,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_byte_o,
    output logic              irq_o
);

    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic              vld;
        logic [BYTE_W-1:0] byte_v;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      accept;

    always_comb begin
        st_d   = st_q;
        accept = data_wr_i && st_q.rdy;
        st_d.vld = accept;
        if (accept) begin
            st_d.rdy    = 1'b0;
            st_d.byte_v = wbyte_i;
        end else if (done_i) begin
            st_d.rdy    = 1'b1;
        end
        if (ie_wr_i) begin
            st_d.ie = ie_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rdy    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_o      = st_q.rdy;
    assign ie_o       = st_q.ie;
    assign tx_valid_o = st_q.vld;
    assign tx_byte_o  = st_q.byte_v;
    assign irq_o      = st_q.rdy & st_q.ie;

    // R6
    tx_pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> !rdy_o);

    // R6
    tx_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |=> !tx_valid_o);

    // R7
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !rdy_o) |=> rdy_o);

    // R8
    tx_busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr_i && !rdy_o) |=> (!tx_valid_o && !rdy_o) || $past(done_i));

endmodule

// File: rtl/cio_console_ctrl.sv
`timescale 1ns/1ps
module cio_console_ctrl
    import cio_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       BYTE_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kb_valid,
    input  logic [BYTE_W-1:0] kb_byte,
    input  logic              tx_done,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq_rx,
    output logic              irq_tx
);

    cio_access_t       acc;
    logic              rx_rdy, rx_ie, tx_rdy, tx_ie;
    logic [BYTE_W-1:0] rx_data;
    logic              rx_ie_wr, tx_ie_wr, tx_data_wr, rx_data_rd;
    logic              wdata_hi_unused;

    assign wdata_hi_unused = ^bus_wdata[DATA_W-1:BYTE_W];

    cio_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr_i (bus_addr),
        .rd_i   (bus_rd),
        .wr_i   (bus_wr),
        .acc_o  (acc)
    );

    always_comb begin
        rx_ie_wr   = acc.wr && (acc.slot == SLOT_RX_CTRL);
        tx_ie_wr   = acc.wr && (acc.slot == SLOT_TX_CTRL);
        tx_data_wr = acc.wr && (acc.slot == SLOT_TX_DATA);
        rx_data_rd = acc.rd && (acc.slot == SLOT_RX_DATA);
    end

    cio_rx_port #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .kb_valid_i (kb_valid),
        .kb_byte_i  (kb_byte),
        .ie_wr_i    (rx_ie_wr),
        .ie_val_i   (bus_wdata[CTRL_IE_BIT]),
        .data_rd_i  (rx_data_rd),
        .rdy_o      (rx_rdy),
        .ie_o       (rx_ie),
        .data_o     (rx_data),
        .irq_o      (irq_rx)
    );

    cio_tx_port #(.BYTE_W(BYTE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ie_wr_i    (tx_ie_wr),
        .ie_val_i   (bus_wdata[CTRL_IE_BIT]),
        .data_wr_i  (tx_data_wr),
        .wbyte_i    (bus_wdata[BYTE_W-1:0]),
        .done_i     (tx_done),
        .rdy_o      (tx_rdy),
        .ie_o       (tx_ie),
        .tx_valid_o (tx_valid),
        .tx_byte_o  (tx_byte),
        .irq_o      (irq_tx)
    );

    // Read mux; every bit not named here stays zero.
    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            unique case (acc.slot)
                SLOT_RX_CTRL: begin
                    bus_rdata[CTRL_RDY_BIT] = rx_rdy;
                    bus_rdata[CTRL_IE_BIT]  = rx_ie;
                end
                SLOT_RX_DATA: bus_rdata[BYTE_W-1:0] = rx_data;
                SLOT_TX_CTRL: begin
                    bus_rdata[CTRL_RDY_BIT] = tx_rdy;
                    bus_rdata[CTRL_IE_BIT]  = tx_ie;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

    // R9
    rx_rdy_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!kb_valid && !rx_data_rd) |=> (rx_rdy == $past(rx_rdy)));

endmodule

// File: tb/tb_cio_console_ctrl.sv
`timescale 1ns/1ps
module tb_cio_console_ctrl;

    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_byte = '0;
    logic        tx_done = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        irq_rx, irq_tx;

    int checks = 0;
    int errors = 0;

    // Reference state
    int m_rx_rdy = 0, m_rx_ie = 0, m_rx_data = 0;
    int m_tx_rdy = 1, m_tx_ie = 0, m_tx_vld = 0, m_tx_byte = 0;

    always #5 clk = ~clk;

    cio_console_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_byte(kb_byte), .tx_done(tx_done),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_rdata(logic [31:0] a, logic rd);
        if (!rd) return 0;
        if (a[31:4] != BASE[31:4] || a[1:0] != 2'b00) return 0;
        case (a[3:2])
            2'd0: return m_rx_ie * 2 + m_rx_rdy;
            2'd1: return m_rx_data;
            2'd2: return m_tx_ie * 2 + m_tx_rdy;
            default: return 0;
        endcase
    endfunction

    // One clock of stimulus: drive after a falling edge, compare, then advance the model.
    task automatic step(string tag, logic [31:0] a, logic rd, logic wr,
                        logic [31:0] wd, logic kv, logic [7:0] kb, logic dn);
        bit hit;
        int idx;
        int acc;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        kb_valid = kv; kb_byte = kb; tx_done = dn;
        #1;
        check(tag, "rdata", int'(bus_rdata), exp_rdata(a, rd));
        check(tag, "irq_rx", int'(irq_rx), m_rx_rdy & m_rx_ie);
        check(tag, "irq_tx", int'(irq_tx), m_tx_rdy & m_tx_ie);
        check(tag, "tx_valid", int'(tx_valid), m_tx_vld);
        if (m_tx_vld != 0) check(tag, "tx_byte", int'(tx_byte), m_tx_byte);
        @(posedge clk);
        hit = (a[31:4] == BASE[31:4]) && (a[1:0] == 2'b00);
        idx = int'(a[3:2]);
        if (kv) begin
            m_rx_rdy = 1; m_rx_data = int'(kb);
        end else if (rd && hit && idx == 1) begin
            m_rx_rdy = 0;
        end
        if (wr && hit && idx == 0) m_rx_ie = int'(wd[1]);
        if (wr && hit && idx == 2) m_tx_ie = int'(wd[1]);
        acc = (wr && hit && idx == 3 && m_tx_rdy == 1) ? 1 : 0;
        m_tx_vld = acc;
        if (acc == 1) begin
            m_tx_rdy = 0; m_tx_byte = int'(wd[7:0]);
        end else if (dn) begin
            m_tx_rdy = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        step(tag, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        step("R1", BASE + 0, 1, 0, 0, 0, 0, 0);
        step("R1", BASE + 8, 1, 0, 0, 0, 0, 0);
        // R12 no read strobe
        step("R12", BASE + 8, 0, 0, 0, 0, 0, 0);
        // R2 arrival then read control and data
        step("R2", 0, 0, 0, 0, 1, 8'h41, 0);
        step("R2", BASE + 0, 1, 0, 0, 0, 0, 0);
        step("R2", BASE + 4, 1, 0, 0, 0, 0, 0);
        // R3 ready cleared by that read
        step("R3", BASE + 0, 1, 0, 0, 0, 0, 0);
        // R4 overwrite before read
        step("R4", 0, 0, 0, 0, 1, 8'h10, 0);
        step("R4", 0, 0, 0, 0, 1, 8'h20, 0);
        step("R4", BASE + 4, 1, 0, 0, 0, 0, 0);
        // R3 read colliding with a new byte
        step("R3", 0, 0, 0, 0, 1, 8'h55, 0);
        step("R3", BASE + 4, 1, 0, 0, 1, 8'h66, 0);
        step("R3", BASE + 0, 1, 0, 0, 0, 0, 0);
        step("R3", BASE + 4, 1, 0, 0, 0, 0, 0);
        // R5 enable receive interrupt
        step("R5", BASE + 0, 0, 1, 32'h2, 0, 0, 0);
        step("R5", BASE + 0, 1, 0, 0, 1, 8'h7E, 0);
        step("R5", BASE + 4, 1, 0, 0, 0, 0, 0);
        idle("R5");
        // R9 ready bits ignore writes
        step("R9", BASE + 0, 0, 1, 32'h1, 0, 0, 0);
        step("R9", BASE + 0, 1, 0, 0, 0, 0, 0);
        step("R9", BASE + 8, 0, 1, 32'h0, 0, 0, 0);
        step("R9", BASE + 8, 1, 0, 0, 0, 0, 0);
        // R10 transmit interrupt
        step("R10", BASE + 8, 0, 1, 32'hFFFF_FFFE, 0, 0, 0);
        step("R10", BASE + 8, 1, 0, 0, 0, 0, 0);
        // R6 accepted transmit, upper data bits set
        step("R6", BASE + 12, 0, 1, 32'hFFFF_FF5A, 0, 0, 0);
        step("R6", BASE + 8, 1, 0, 0, 0, 0, 0);
        // R8 write while busy
        step("R8", BASE + 12, 0, 1, 32'h33, 0, 0, 0);
        step("R8", BASE + 8, 1, 0, 0, 0, 0, 0);
        // R7 completion
        step("R7", 0, 0, 0, 0, 0, 0, 1);
        step("R7", BASE + 8, 1, 0, 0, 0, 0, 0);
        // R7 done together with a new accepted write
        step("R7", BASE + 12, 0, 1, 32'hC3, 0, 0, 1);
        idle("R7");
        step("R7", 0, 0, 0, 0, 0, 0, 1);
        // R11 outside window, misaligned, transmit data read
        step("R11", 32'h7FFF_000C, 0, 1, 32'h99, 0, 0, 0);
        step("R11", 32'h7FFF_0008, 1, 0, 0, 0, 0, 0);
        step("R11", BASE + 9, 0, 1, 32'h0, 0, 0, 0);
        step("R11", BASE + 9, 1, 0, 0, 0, 0, 0);
        step("R11", BASE + 13, 0, 1, 32'h44, 0, 0, 0);
        step("R11", BASE + 12, 1, 0, 0, 0, 0, 0);
        step("R11", BASE + 8, 1, 0, 0, 0, 0, 0);

        // Random mixed traffic, every requirement exercised again
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = (($urandom % 8) == 0) ? $urandom : BASE + ($urandom % 16);
            step("R1-mix", a, 1'($urandom), 1'($urandom), $urandom,
                 1'(($urandom % 4) == 0), 8'($urandom), 1'(($urandom % 3) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule